// File: doc/BRIEF.md
# SDR SDRAM Command Bus Monitor with Bank Tracking

This block watches the command pins of a single-rank SDR SDRAM bus without driving anything. On every rising clock edge it decodes the command, updates a model of which of the four internal banks hold an open row and which row that is, and reports any command that breaks the bank protocol. Examples are an access to a closed bank, opening a row in a bank that is already open, or refreshing while a row is still open. It tells apart the two refresh variants selected by the clock-enable pin. It follows auto-precharge per bank, using the burst length last written through LOAD MODE. It is meant to sit beside a memory controller in simulation or in silicon, as a protocol watchdog.

Each bank runs its own state machine with three states. IDLE goes to OPEN on an ACTIVE to that bank. OPEN goes to IDLE on a PRECHARGE that selects the bank. OPEN goes to AP_WAIT on a READ or WRITE with the auto-precharge bit set. AP_WAIT goes to IDLE either when its burst countdown expires or on a PRECHARGE that selects the bank. A monitor state machine has two states. RUN goes to SELF_REFRESH on a refresh command sampled with clock-enable low. SELF_REFRESH goes back to RUN on the first cycle sampled with clock-enable high. While in SELF_REFRESH, commands do not reach the bank machines.

Each violation is reported as a registered one-cycle pulse carrying a code. The pulse, the open flags and the row values all appear after the clock edge that sampled the command.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: After reset, no bank is open, `viol_valid` is low, `in_selfref` is low, and the burst length used for auto-precharge is 1.
- R2: A cycle with `cs_n` high is an inhibit. It changes no bank and raises no violation, whatever the other pins carry.
- R3: ACTIVE ({ras_n,cas_n,we_n}=011, cs_n low) to an idle bank `ba` sets that bank's open flag. It also loads `addr` into that bank's row field, which is bits [b*13 +: 13] of `bank_row`.
- R4: ACTIVE to a bank that is already open, including one that is waiting for auto-precharge, raises code 2 and leaves the stored row unchanged.
- R5: READ (101) or WRITE (100) to an idle bank raises code 1 and opens nothing.
- R6: PRECHARGE (010) with `addr[10]` high closes every bank. With `addr[10]` low it closes only bank `ba`.
- R7: LOAD MODE (000) with `addr[12]` low stores `addr[2:0]` as the burst code: 000=1, 001=2, 010=4, 011=8, 111=full page, and any other value counts as 1. With `addr[12]` high it raises code 4 and keeps the previous mode.
- R8: READ or WRITE with `addr[10]` high to an open bank keeps the bank open. The bank closes at the clock edge that comes BL edges after the access edge. With `addr[10]` low the bank stays open, because auto-precharge does not persist.
- R9: READ or WRITE to a bank that is waiting for auto-precharge raises code 6 and does not change its countdown. Auto-precharge while the mode is full page raises code 7 and the bank stays open.
- R10: Refresh (001) with `cke` high is an auto refresh. The monitor stays in RUN, address pins are ignored, and code 3 is raised if any bank is open.
- R11: Refresh with `cke` low enters self refresh (`in_selfref` high). Code 3 is raised if any bank is open.
- R12: In self refresh, any command other than NOP or inhibit raises code 5 and does not reach the banks. The first cycle with `cke` high returns the monitor to RUN.
- R13: A violation appears as `viol_valid` high for exactly the one cycle after the offending edge. NOP (111) and BURST TERMINATE (110) change no bank and raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples commands |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Address pins (row, column, A10 modifier, op-code) |
| ba | input | 2 | Bank select |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 52 | Row held by each bank, 13 bits per bank |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Violation code, 0 when none |
| in_selfref | output | 1 | High while in self refresh |

## Verification
The bench targets the exact close point of auto-precharge for burst lengths 1, 4 and 8. A countdown that is off by one would close the bank one sample too early or too late. A mode register that ignores a guarded LOAD MODE incorrectly would shift the close point after a rejected op-code. It drives inhibits that carry the patterns of destructive commands, and A10-low accesses after an auto-precharge. A decoder that ignores `cs_n`, or that lets auto-precharge persist, would close banks there. Around self refresh it sends a command on the exit cycle and checks that the command is flagged but does not open a bank. It also checks that refresh with open banks is reported for both `cke` levels.

// File: rtl/sdrmon_pkg.sv
`timescale 1ns/1ps
package sdrmon_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_AREF,
        CMD_SREF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE        = 4'd0,
        ERR_RW_IDLE     = 4'd1,
        ERR_ACT_OPEN    = 4'd2,
        ERR_REF_OPEN    = 4'd3,
        ERR_LMR_A12     = 4'd4,
        ERR_IN_SELFREF  = 4'd5,
        ERR_RW_APWAIT   = 4'd6,
        ERR_AP_FULLPAGE = 4'd7
    } err_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_APWAIT
    } bank_st_e;

    typedef enum logic {
        MON_RUN,
        MON_SELFREF
    } mon_st_e;

endpackage

// File: rtl/sdrmon_decode.sv
`timescale 1ns/1ps
module sdrmon_decode
    import sdrmon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_INHIBIT;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000: cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdrmon_mode.sv
`timescale 1ns/1ps
module sdrmon_mode #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       bl_code,
    output logic [CNT_W-1:0] ap_len,
    output logic             full_page
);

    logic [2:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= 3'b000;
        end else if (load) begin
            code_q <= bl_code;
        end
    end

    // Remaining edges after the access edge before the bank closes.
    always_comb begin
        unique case (code_q)
            3'b001:  ap_len = CNT_W'(1);
            3'b010:  ap_len = CNT_W'(3);
            3'b011:  ap_len = CNT_W'(7);
            default: ap_len = '0;
        endcase
        full_page = (code_q == 3'b111);
    end

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));

endmodule

// File: rtl/sdrmon_bank.sv
`timescale 1ns/1ps
module sdrmon_bank
    import sdrmon_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int CNT_W  = 3,
    parameter int AP_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             hit,
    input  logic [ROW_W-1:0] addr,
    input  logic [CNT_W-1:0] ap_len,
    input  logic             full_page,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output err_e             err
);

    bank_st_e         st_q, st_d;
    logic [ROW_W-1:0] row_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pre_hit;
    logic             acc;
    logic             act;

    assign pre_hit = (cmd == CMD_PRE) && (addr[AP_BIT] || hit);
    assign acc     = ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit;
    assign act     = (cmd == CMD_ACT) && hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            row_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            row_q <= row_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and error output
    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        cnt_d = cnt_q;
        err   = ERR_NONE;
        unique case (st_q)
            BK_IDLE: begin
                if (act) begin
                    st_d  = BK_OPEN;
                    row_d = addr;
                end else if (acc) begin
                    err = ERR_RW_IDLE;
                end
            end
            BK_OPEN: begin
                if (act) begin
                    err = ERR_ACT_OPEN;
                end else if (pre_hit) begin
                    st_d = BK_IDLE;
                end else if (acc && addr[AP_BIT]) begin
                    if (full_page) begin
                        err = ERR_AP_FULLPAGE;
                    end else begin
                        st_d  = BK_APWAIT;
                        cnt_d = ap_len;
                    end
                end
            end
            BK_APWAIT: begin
                if (act) begin
                    err = ERR_ACT_OPEN;
                end else if (acc) begin
                    err = ERR_RW_APWAIT;
                end
                if (pre_hit || (cnt_q == '0)) begin
                    st_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    assign is_open = (st_q != BK_IDLE);

    assert_act_loads_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_IDLE && act) |=> (is_open && row_q == $past(addr)));

    assert_rw_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_IDLE && acc) |=> (st_q == BK_IDLE));

    assert_ap_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_APWAIT && cnt_q == '0) |=> (st_q == BK_IDLE));

    assert_act_keeps_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != BK_IDLE && act) |=> $stable(row_q));

endmodule

// File: rtl/sdr_cmd_monitor.sv
`timescale 1ns/1ps
module sdr_cmd_monitor
    import sdrmon_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANKS  = 4,
    parameter int MAX_BL = 8,
    parameter int AP_BIT = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [ROW_W-1:0]       addr,
    input  logic [$clog2(BANKS)-1:0] ba,
    output logic [BANKS-1:0]       bank_open,
    output logic [BANKS*ROW_W-1:0] bank_row,
    output logic                   viol_valid,
    output logic [3:0]             viol_code,
    output logic                   in_selfref
);

    localparam int BA_W      = $clog2(BANKS);
    localparam int CNT_W     = $clog2(MAX_BL);
    localparam int GUARD_BIT = ROW_W - 1;

    cmd_e             cmd_raw;
    cmd_e             bank_cmd;
    mon_st_e          mon_q, mon_d;
    err_e             top_err;
    err_e             bank_err [BANKS];
    logic [BANKS-1:0] bank_err_nz;
    logic [3:0]       err_all;
    logic             any_open;
    logic             lmr_load;
    logic [CNT_W-1:0] ap_len;
    logic             full_page;

    sdrmon_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_raw)
    );

    sdrmon_mode #(.CNT_W(CNT_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lmr_load),
        .bl_code   (addr[2:0]),
        .ap_len    (ap_len),
        .full_page (full_page)
    );

    assign bank_cmd = (mon_q == MON_RUN) ? cmd_raw : CMD_NOP;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sdrmon_bank #(
            .ROW_W  (ROW_W),
            .CNT_W  (CNT_W),
            .AP_BIT (AP_BIT)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (bank_cmd),
            .hit       (ba == BA_W'(b)),
            .addr      (addr),
            .ap_len    (ap_len),
            .full_page (full_page),
            .is_open   (bank_open[b]),
            .row_q     (bank_row[b*ROW_W +: ROW_W]),
            .err       (bank_err[b])
        );
        assign bank_err_nz[b] = (bank_err[b] != ERR_NONE);
    end

    assign any_open = |bank_open;

    // Monitor state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= MON_RUN;
        end else begin
            mon_q <= mon_d;
        end
    end

    // Monitor next state and top-level checks
    always_comb begin
        mon_d    = mon_q;
        top_err  = ERR_NONE;
        lmr_load = 1'b0;
        unique case (mon_q)
            MON_RUN: begin
                if (cmd_raw == CMD_AREF) begin
                    if (any_open) top_err = ERR_REF_OPEN;
                end else if (cmd_raw == CMD_SREF) begin
                    if (any_open) top_err = ERR_REF_OPEN;
                    mon_d = MON_SELFREF;
                end else if (cmd_raw == CMD_LMR) begin
                    if (addr[GUARD_BIT]) top_err = ERR_LMR_A12;
                    else                 lmr_load = 1'b1;
                end
            end
            MON_SELFREF: begin
                if (cmd_raw != CMD_INHIBIT && cmd_raw != CMD_NOP) begin
                    top_err = ERR_IN_SELFREF;
                end
                if (cke) mon_d = MON_RUN;
            end
            default: mon_d = MON_RUN;
        endcase
    end

    // Merge error sources; at most one source is active per cycle
    always_comb begin
        err_all = top_err;
        for (int b = 0; b < BANKS; b++) begin
            err_all = err_all | bank_err[b];
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_code  <= 4'd0;
        end else begin
            viol_valid <= (err_all != 4'd0);
            viol_code  <= err_all;
        end
    end

    assign in_selfref = (mon_q == MON_SELFREF);

    assert_one_bank_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_err_nz));

    assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q == MON_RUN && cmd_raw == CMD_PRE && addr[AP_BIT]) |=> (bank_open == '0));

    assert_lmr_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q == MON_RUN && cmd_raw == CMD_LMR && addr[GUARD_BIT])
        |=> (viol_valid && viol_code == ERR_LMR_A12));

    assert_selfref_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q == MON_SELFREF && !cke) |=> in_selfref);

    assert_selfref_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q == MON_SELFREF && cmd_raw == CMD_ACT && bank_open == '0)
        |=> (bank_open == '0));

    assert_aref_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q == MON_RUN && cmd_raw == CMD_AREF) |=> !in_selfref);

endmodule

// File: tb/sdr_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdr_cmd_monitor_bench;

    localparam logic [2:0] OP_NOP = 3'b111;
    localparam logic [2:0] OP_ACT = 3'b011;
    localparam logic [2:0] OP_RD  = 3'b101;
    localparam logic [2:0] OP_WR  = 3'b100;
    localparam logic [2:0] OP_BST = 3'b110;
    localparam logic [2:0] OP_PRE = 3'b010;
    localparam logic [2:0] OP_REF = 3'b001;
    localparam logic [2:0] OP_LMR = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [3:0]  bank_open;
    logic [51:0] bank_row;
    logic        viol_valid;
    logic [3:0]  viol_code;
    logic        in_selfref;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sdr_cmd_monitor u_sdr_cmd_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .ba         (ba),
        .bank_open  (bank_open),
        .bank_row   (bank_row),
        .viol_valid (viol_valid),
        .viol_code  (viol_code),
        .in_selfref (in_selfref)
    );

    function automatic logic [12:0] row_of(input int b);
        return bank_row[b*13 +: 13];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command at a falling edge, return at the next falling edge
    task automatic drive(input logic k, input logic cs, input logic [2:0] op,
                         input logic [12:0] a, input logic [1:0] b);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = op; addr = a; ba = b;
        @(negedge clk);
    endtask

    task automatic nop();
        drive(1'b1, 1'b0, OP_NOP, 13'h0, 2'd0);
    endtask

    task automatic act(input logic [1:0] b, input logic [12:0] r);
        drive(1'b1, 1'b0, OP_ACT, r, b);
    endtask

    task automatic rd(input logic [1:0] b, input logic ap);
        drive(1'b1, 1'b0, OP_RD, {2'b00, ap, 10'h015}, b);
    endtask

    task automatic wr(input logic [1:0] b, input logic ap);
        drive(1'b1, 1'b0, OP_WR, {2'b00, ap, 10'h2a0}, b);
    endtask

    task automatic pre(input logic [1:0] b, input logic all);
        drive(1'b1, 1'b0, OP_PRE, {2'b00, all, 10'h0}, b);
    endtask

    task automatic lmr(input logic [12:0] a);
        drive(1'b1, 1'b0, OP_LMR, a, 2'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 open after reset", bank_open, 4'b0000);
        chk("R1 viol after reset", viol_valid, 1'b0);
        chk("R1 selfref after reset", in_selfref, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_activate();
        act(2'd1, 13'h1abc);
        chk("R3 open after act b1", bank_open, 4'b0010);
        chk("R3 row b1", row_of(1), 13'h1abc);
        chk("R3 no viol", viol_valid, 1'b0);
        act(2'd3, 13'h0005);
        chk("R3 open after act b3", bank_open, 4'b1010);
        chk("R3 row b3", row_of(3), 13'h0005);
        pre(2'd0, 1'b1);
        chk("R6 pre all", bank_open, 4'b0000);
    endtask

    task automatic t_act_open();
        act(2'd2, 13'h0123);
        act(2'd2, 13'h0456);
        chk("R4 viol valid", viol_valid, 1'b1);
        chk("R4 viol code", viol_code, 4'd2);
        chk("R4 row kept", row_of(2), 13'h0123);
        nop();
        chk("R13 pulse one cycle", viol_valid, 1'b0);
        pre(2'd2, 1'b0);
        chk("R6 single pre b2", bank_open, 4'b0000);
        act(2'd0, 13'h0001);
        act(2'd3, 13'h0002);
        pre(2'd0, 1'b0);
        chk("R6 single pre leaves b3", bank_open, 4'b1000);
        pre(2'd0, 1'b1);
    endtask

    task automatic t_rw_idle();
        rd(2'd1, 1'b0);
        chk("R5 read idle code", viol_code, 4'd1);
        chk("R5 read idle valid", viol_valid, 1'b1);
        wr(2'd2, 1'b1);
        chk("R5 write idle code", viol_code, 4'd1);
        chk("R5 nothing opened", bank_open, 4'b0000);
        nop();
    endtask

    task automatic t_inhibit();
        act(2'd0, 13'h0aaa);
        drive(1'b1, 1'b1, OP_LMR, 13'h1fff, 2'd0);
        chk("R2 inhibit lmr pattern viol", viol_valid, 1'b0);
        drive(1'b1, 1'b1, OP_PRE, 13'h0400, 2'd0);
        chk("R2 inhibit pre pattern open", bank_open, 4'b0001);
        drive(1'b1, 1'b1, OP_ACT, 13'h0bbb, 2'd0);
        chk("R2 inhibit act pattern viol", viol_valid, 1'b0);
        chk("R2 inhibit act pattern row", row_of(0), 13'h0aaa);
        drive(1'b1, 1'b0, OP_BST, 13'h0400, 2'd0);
        chk("R13 bst no change", bank_open, 4'b0001);
        chk("R13 bst no viol", viol_valid, 1'b0);
        pre(2'd0, 1'b1);
    endtask

    task automatic t_ap_default();
        act(2'd0, 13'h0010);
        rd(2'd0, 1'b1);
        chk("R8 bl1 open at access", bank_open, 4'b0001);
        nop();
        chk("R1 bl1 default closes", bank_open, 4'b0000);
        act(2'd1, 13'h0020);
        wr(2'd1, 1'b0);
        nop();
        nop();
        chk("R8 no ap stays open", bank_open, 4'b0010);
        rd(2'd1, 1'b1);
        nop();
        chk("R8 ap not persistent then closes", bank_open, 4'b0000);
    endtask

    task automatic t_lmr();
        lmr(13'h0002);
        chk("R7 lmr ok no viol", viol_valid, 1'b0);
        act(2'd2, 13'h0033);
        wr(2'd2, 1'b1);
        for (int i = 1; i <= 3; i++) begin
            nop();
            chk("R8 bl4 still open", bank_open[2], 1'b1);
        end
        nop();
        chk("R8 bl4 closed", bank_open[2], 1'b0);
        lmr(13'h1003);
        chk("R7 a12 code", viol_code, 4'd4);
        act(2'd0, 13'h0044);
        rd(2'd0, 1'b1);
        repeat (3) nop();
        chk("R7 mode kept bl4 open", bank_open[0], 1'b1);
        nop();
        chk("R7 mode kept bl4 closed", bank_open[0], 1'b0);
        lmr(13'h0003);
        act(2'd3, 13'h0055);
        rd(2'd3, 1'b1);
        repeat (7) nop();
        chk("R8 bl8 open at 7", bank_open[3], 1'b1);
        nop();
        chk("R8 bl8 closed at 8", bank_open[3], 1'b0);
        lmr(13'h0004);
        act(2'd1, 13'h0066);
        rd(2'd1, 1'b1);
        nop();
        chk("R7 reserved code as bl1", bank_open[1], 1'b0);
    endtask

    task automatic t_ap_pending();
        lmr(13'h0002);
        act(2'd1, 13'h0077);
        rd(2'd1, 1'b1);
        rd(2'd1, 1'b0);
        chk("R9 access during ap code", viol_code, 4'd6);
        act(2'd1, 13'h0099);
        chk("R4 act during ap code", viol_code, 4'd2);
        chk("R4 act during ap row", row_of(1), 13'h0077);
        nop();
        chk("R9 countdown kept open", bank_open[1], 1'b1);
        nop();
        chk("R9 countdown kept closed", bank_open[1], 1'b0);
        lmr(13'h0007);
        act(2'd2, 13'h0088);
        rd(2'd2, 1'b1);
        chk("R9 full page ap code", viol_code, 4'd7);
        nop();
        nop();
        chk("R9 full page stays open", bank_open[2], 1'b1);
        pre(2'd0, 1'b1);
        lmr(13'h0000);
    endtask

    task automatic t_autoref();
        drive(1'b1, 1'b0, OP_REF, 13'h1fff, 2'd3);
        chk("R10 aref clean no viol", viol_valid, 1'b0);
        chk("R10 aref stays run", in_selfref, 1'b0);
        chk("R10 aref opens nothing", bank_open, 4'b0000);
        act(2'd0, 13'h0101);
        drive(1'b1, 1'b0, OP_REF, 13'h0000, 2'd0);
        chk("R10 aref with open code", viol_code, 4'd3);
        chk("R10 aref bank kept", bank_open, 4'b0001);
        pre(2'd0, 1'b1);
    endtask

    task automatic t_selfref();
        drive(1'b0, 1'b0, OP_REF, 13'h0000, 2'd0);
        chk("R11 sref entered", in_selfref, 1'b1);
        chk("R11 sref clean", viol_valid, 1'b0);
        drive(1'b0, 1'b0, OP_ACT, 13'h0202, 2'd1);
        chk("R12 cmd in sref code", viol_code, 4'd5);
        chk("R12 cmd in sref blocked", bank_open, 4'b0000);
        drive(1'b0, 1'b0, OP_NOP, 13'h0000, 2'd0);
        chk("R12 nop in sref clean", viol_valid, 1'b0);
        chk("R12 still in sref", in_selfref, 1'b1);
        nop();
        chk("R12 exit on cke", in_selfref, 1'b0);
        chk("R12 exit clean", viol_valid, 1'b0);
        act(2'd0, 13'h0303);
        drive(1'b0, 1'b0, OP_REF, 13'h0000, 2'd0);
        chk("R11 sref with open code", viol_code, 4'd3);
        chk("R11 sref with open entered", in_selfref, 1'b1);
        act(2'd2, 13'h0404);
        chk("R12 exit cmd code", viol_code, 4'd5);
        chk("R12 exit cmd left sref", in_selfref, 1'b0);
        chk("R12 exit cmd not applied", bank_open, 4'b0001);
        pre(2'd0, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_activate();
        t_act_open();
        t_rw_idle();
        t_inhibit();
        t_ap_default();
        t_lmr();
        t_ap_pending();
        t_autoref();
        t_selfref();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL R13 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule